// File: doc/BRIEF.md
# Virtualization Intercept Classifier

This unit decides whether an event raised while a guest is running must leave the guest and return control to the host. At guest entry, the surrounding sequencer loads six intercept vectors with one load strobe: a read mask and a write mask for control registers, a read mask and a write mask for debug registers, an exception mask and a wide general intercept vector. The sequencer then issues queries. Each query carries an exit-type code and the current guest-mode flag, and one cycle later the unit answers with a registered hit bit and a response-valid pulse.

The unit splits the exit-code space into disjoint windows. Each window indexes its own mask. Any code outside those windows counts as a general event and indexes the general vector by its distance from the interrupt exit code. When control returns to the host, a clear strobe zeroes the general vector and the exception mask. The register masks keep their contents.

Top module: `intercept_classifier`

## Requirements
- R1: After reset, `resp_valid` and `resp_hit` are 0 and every intercept vector is zero, so any query reports no hit.
- R2: A query with `guest_mode` = 0 always reports `resp_hit` = 0, whatever the vectors hold.
- R3: Codes 0x000 to 0x008 test bit (code − 0x000) of the control-register read mask. Codes 0x009 to 0x00F belong to no window and report no hit.
- R4: Codes 0x010 to 0x018 test bit (code − 0x010) of the control-register write mask.
- R5: Codes 0x020 to 0x027 test bit (code − 0x020) of the debug-register read mask, and codes 0x030 to 0x037 test bit (code − 0x030) of the debug-register write mask. Codes 0x028 and 0x038 report no hit.
- R6: Codes 0x040 to 0x05F test bit (code − 0x040) of the 32-bit exception mask.
- R7: Codes 0x060 to 0x09F test bit (code − 0x060) of the 64-bit general vector. Codes from 0x0A0 upward, and codes below 0x060 that fall in no window, report no hit.
- R8: `host_return` zeroes the general vector and the exception mask at the next edge and leaves the four register masks unchanged. If `load` and `host_return` arrive in the same cycle, the general vector and the exception mask end up zero and the register masks take the new values.
- R9: `resp_valid` is high for exactly the cycle after each cycle with `query_valid` high, and it is 0 otherwise. `resp_hit` is 0 whenever `resp_valid` is 0.
- R10: A query in the same cycle as `load` is answered from the vectors held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Captures all six intercept vectors |
| host_return | input | 1 | Clears the general vector and the exception mask |
| cr_rd_mask | input | 16 | Control-register read mask to load |
| cr_wr_mask | input | 16 | Control-register write mask to load |
| dr_rd_mask | input | 16 | Debug-register read mask to load |
| dr_wr_mask | input | 16 | Debug-register write mask to load |
| exc_mask | input | 32 | Exception mask to load |
| gen_vec | input | 64 | General intercept vector to load |
| query_valid | input | 1 | Query strobe |
| guest_mode | input | 1 | 1 while a guest is running |
| exit_code | input | 12 | Exit-type code of the query |
| resp_valid | output | 1 | Pulses one cycle after a query |
| resp_hit | output | 1 | The queried event must exit the guest |

## Verification
The assertions assume that each query is a single-cycle strobe with a stable code and flag, and that `load` and `host_return` are synchronous strobes. They place no constraint on how these strobes are interleaved. Random stimulus draws codes from 0x000 to 0x0BF, so it covers every window, the gaps between windows and the region past the general vector. It mixes in random loads, host returns and guest-flag values, including same-cycle load, clear and query combinations. Directed steps then hit the last bit of each window and the first code past it.

// File: rtl/intercept_classifier.sv
module intercept_classifier #(
  parameter int CODE_W   = 12,
  parameter int MASK_W   = 16,
  parameter int EXC_W    = 32,
  parameter int GEN_W    = 64,
  parameter int CR_SPAN  = 9,
  parameter int DR_SPAN  = 8,
  parameter int CRR_BASE = 'h000,
  parameter int CRW_BASE = 'h010,
  parameter int DRR_BASE = 'h020,
  parameter int DRW_BASE = 'h030,
  parameter int EXC_BASE = 'h040,
  parameter int GEN_BASE = 'h060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              host_return,
  input  logic [MASK_W-1:0] cr_rd_mask,
  input  logic [MASK_W-1:0] cr_wr_mask,
  input  logic [MASK_W-1:0] dr_rd_mask,
  input  logic [MASK_W-1:0] dr_wr_mask,
  input  logic [EXC_W-1:0]  exc_mask,
  input  logic [GEN_W-1:0]  gen_vec,
  input  logic              query_valid,
  input  logic              guest_mode,
  input  logic [CODE_W-1:0] exit_code,
  output logic              resp_valid,
  output logic              resp_hit
);

  localparam logic [CODE_W-1:0] CRR_LO = CODE_W'(CRR_BASE);
  localparam logic [CODE_W-1:0] CRR_HI = CODE_W'(CRR_BASE + CR_SPAN - 1);
  localparam logic [CODE_W-1:0] CRW_LO = CODE_W'(CRW_BASE);
  localparam logic [CODE_W-1:0] CRW_HI = CODE_W'(CRW_BASE + CR_SPAN - 1);
  localparam logic [CODE_W-1:0] DRR_LO = CODE_W'(DRR_BASE);
  localparam logic [CODE_W-1:0] DRR_HI = CODE_W'(DRR_BASE + DR_SPAN - 1);
  localparam logic [CODE_W-1:0] DRW_LO = CODE_W'(DRW_BASE);
  localparam logic [CODE_W-1:0] DRW_HI = CODE_W'(DRW_BASE + DR_SPAN - 1);
  localparam logic [CODE_W-1:0] EXC_LO = CODE_W'(EXC_BASE);
  localparam logic [CODE_W-1:0] EXC_HI = CODE_W'(EXC_BASE + EXC_W - 1);
  localparam logic [CODE_W-1:0] GEN_LO = CODE_W'(GEN_BASE);
  localparam logic [CODE_W-1:0] GEN_HI = CODE_W'(GEN_BASE + GEN_W - 1);

  logic [MASK_W-1:0] cr_rd_q, cr_wr_q, dr_rd_q, dr_wr_q;
  logic [EXC_W-1:0]  exc_q;
  logic [GEN_W-1:0]  gen_q;
  logic              sel_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_rd_q <= '0;
      cr_wr_q <= '0;
      dr_rd_q <= '0;
      dr_wr_q <= '0;
      exc_q   <= '0;
      gen_q   <= '0;
    end else begin
      if (load) begin
        cr_rd_q <= cr_rd_mask;
        cr_wr_q <= cr_wr_mask;
        dr_rd_q <= dr_rd_mask;
        dr_wr_q <= dr_wr_mask;
        exc_q   <= exc_mask;
        gen_q   <= gen_vec;
      end
      if (host_return) begin
        exc_q <= '0;
        gen_q <= '0;
      end
    end
  end

  // Each window's offset is only used inside that window, so no shift goes past its vector.
  always_comb begin
    sel_hit = 1'b0;
    if (exit_code >= CRR_LO && exit_code <= CRR_HI)
      sel_hit = |(cr_rd_q & (MASK_W'(1) << (exit_code - CRR_LO)));
    else if (exit_code >= CRW_LO && exit_code <= CRW_HI)
      sel_hit = |(cr_wr_q & (MASK_W'(1) << (exit_code - CRW_LO)));
    else if (exit_code >= DRR_LO && exit_code <= DRR_HI)
      sel_hit = |(dr_rd_q & (MASK_W'(1) << (exit_code - DRR_LO)));
    else if (exit_code >= DRW_LO && exit_code <= DRW_HI)
      sel_hit = |(dr_wr_q & (MASK_W'(1) << (exit_code - DRW_LO)));
    else if (exit_code >= EXC_LO && exit_code <= EXC_HI)
      sel_hit = |(exc_q & (EXC_W'(1) << (exit_code - EXC_LO)));
    else if (exit_code >= GEN_LO && exit_code <= GEN_HI)
      sel_hit = |(gen_q & (GEN_W'(1) << (exit_code - GEN_LO)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
    end else begin
      resp_valid <= query_valid;
      resp_hit   <= query_valid & guest_mode & sel_hit;
    end
  end

  AST_RESP_AFTER_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    query_valid |=> resp_valid); // R9
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !query_valid |=> !resp_valid && !resp_hit); // R9
  AST_HOST_MODE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    query_valid && !guest_mode |=> !resp_hit); // R2
  AST_PAST_GENERAL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    query_valid && exit_code > GEN_HI |=> !resp_hit); // R7
  AST_RETURN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    host_return |=> gen_q == '0 && exc_q == '0); // R8
  AST_RETURN_KEEPS_CR: assert property (@(posedge clk) disable iff (!rst_n)
    host_return && !load |=> $stable(cr_rd_q) && $stable(dr_wr_q)); // R8

endmodule

// File: tb/test_intercept_classifier.sv
`timescale 1ns/1ps
module test_intercept_classifier;
  logic clk = 0, rst_n = 0;
  logic load = 0, host_return = 0, query_valid = 0, guest_mode = 0;
  logic [15:0] cr_rd_mask = 0, cr_wr_mask = 0, dr_rd_mask = 0, dr_wr_mask = 0;
  logic [31:0] exc_mask = 0;
  logic [63:0] gen_vec = 0;
  logic [11:0] exit_code = 0;
  logic resp_valid, resp_hit;

  logic [15:0] m_crr = 0, m_crw = 0, m_drr = 0, m_drw = 0;
  logic [31:0] m_exc = 0;
  logic [63:0] m_gen = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intercept_classifier i_intercept_classifier (
    .clk(clk), .rst_n(rst_n), .load(load), .host_return(host_return),
    .cr_rd_mask(cr_rd_mask), .cr_wr_mask(cr_wr_mask), .dr_rd_mask(dr_rd_mask),
    .dr_wr_mask(dr_wr_mask), .exc_mask(exc_mask), .gen_vec(gen_vec),
    .query_valid(query_valid), .guest_mode(guest_mode), .exit_code(exit_code),
    .resp_valid(resp_valid), .resp_hit(resp_hit));

  function automatic bit exp_hit(input int c, input bit g);
    if (!g) return 0;
    if (c >= 'h00 && c <= 'h08) return m_crr[c];
    if (c >= 'h10 && c <= 'h18) return m_crw[c - 'h10];
    if (c >= 'h20 && c <= 'h27) return m_drr[c - 'h20];
    if (c >= 'h30 && c <= 'h37) return m_drw[c - 'h30];
    if (c >= 'h40 && c <= 'h5f) return m_exc[c - 'h40];
    if (c >= 'h60 && c <= 'h9f) return m_gen[c - 'h60];
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit ld, input bit hr, input bit qv, input bit g,
                      input int code, input string req);
    bit eh;
    @(negedge clk);
    load = ld; host_return = hr; query_valid = qv; guest_mode = g;
    exit_code = 12'(code);
    eh = qv && exp_hit(code, g);
    @(posedge clk);
    if (ld) begin
      m_crr = cr_rd_mask; m_crw = cr_wr_mask; m_drr = dr_rd_mask;
      m_drw = dr_wr_mask; m_exc = exc_mask; m_gen = gen_vec;
    end
    if (hr) begin m_exc = 0; m_gen = 0; end
    #5;
    check(resp_valid == qv, {req, " valid"}, int'(resp_valid), int'(qv));
    check(resp_hit == eh, {req, " hit"}, int'(resp_hit), int'(eh));
  endtask

  task automatic set_vecs(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                          input logic [15:0] d, input logic [31:0] e, input logic [63:0] f);
    cr_rd_mask = a; cr_wr_mask = b; dr_rd_mask = c; dr_wr_mask = d; exc_mask = e; gen_vec = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #5;
    check(resp_valid == 0 && resp_hit == 0, "R1 reset outputs", int'(resp_valid), 0);
    @(negedge clk); rst_n = 1;
    step(0, 0, 1, 1, 'h60, "R1 zero vectors");
    step(0, 0, 1, 1, 'h00, "R1 zero cr mask");
    set_vecs(16'hffff, 16'hffff, 16'hffff, 16'hffff, 32'hffff_ffff, 64'hffff_ffff_ffff_ffff);
    step(1, 0, 1, 1, 'h60, "R10 same-cycle load uses old");
    step(0, 0, 1, 1, 'h60, "R7 general bit0");
    step(0, 0, 1, 0, 'h60, "R2 host mode");
    step(0, 0, 1, 0, 'h08, "R2 host mode cr");
    step(0, 0, 1, 1, 'h08, "R3 cr read top");
    step(0, 0, 1, 1, 'h09, "R3 cr read gap");
    step(0, 0, 1, 1, 'h18, "R4 cr write top");
    step(0, 0, 1, 1, 'h28, "R5 dr read past");
    step(0, 0, 1, 1, 'h38, "R5 dr write past");
    step(0, 0, 1, 1, 'h9f, "R7 general bit63");
    step(0, 0, 1, 1, 'ha0, "R7 past general");
    step(0, 0, 0, 1, 'h60, "R9 no query");
    set_vecs(16'h0100, 16'h0002, 16'h0080, 16'h0001, 32'h8000_0000, 64'h8000_0000_0000_0001);
    step(1, 0, 0, 1, 0, "R10 load");
    step(0, 0, 1, 1, 'h07, "R3 cr read bit7 clear");
    step(0, 0, 1, 1, 'h11, "R4 cr write bit1");
    step(0, 0, 1, 1, 'h27, "R5 dr read bit7");
    step(0, 0, 1, 1, 'h26, "R5 dr read bit6");
    step(0, 0, 1, 1, 'h30, "R5 dr write bit0");
    step(0, 0, 1, 1, 'h5f, "R6 exception bit31");
    step(0, 0, 1, 1, 'h5e, "R6 exception bit30");
    step(0, 1, 0, 1, 0, "R8 host return");
    step(0, 0, 1, 1, 'h5f, "R8 exception cleared");
    step(0, 0, 1, 1, 'h9f, "R8 general cleared");
    step(0, 0, 1, 1, 'h08, "R8 cr read kept");
    set_vecs(16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'hffff_ffff, 64'hffff_ffff_ffff_ffff);
    step(1, 1, 0, 1, 0, "R8 clear wins");
    step(0, 0, 1, 1, 'h70, "R8 general after clear+load");
    step(0, 0, 1, 1, 'h41, "R8 exception after clear+load");
    for (int k = 0; k < 600; k++) begin
      bit ld = ($urandom_range(0, 9) == 0);
      bit hr = ($urandom_range(0, 14) == 0);
      if (ld) set_vecs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                       $urandom, {$urandom, $urandom});
      step(ld, hr, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) != 0),
           int'($urandom_range(0, 'hbf)), "R3 R4 R5 R6 R7 R9 random");
    end
    step(0, 0, 0, 0, 0, "R9 idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule